// File: doc/BRIEF.md
# Parallel Bus ROM Read Responder

This block answers read cycles on an external parallel bus as a read-only memory would. An active-low read strobe opens a cycle. When it falls, the block samples eight low address lines and places them below an upper-address field that was loaded beforehand. It clears the byte bit and queues the address to an internal lookup stage. It then asserts the data-bus output enable and waits for the 16-bit word to come back through a response FIFO. It drives that word until the strobe rises, and then releases the bus.

A marker output changes state at two fixed points. These are the address capture and the step after the data is driven, so the response latency can be measured on a scope. The upper-address field is reloaded from a configuration input at every capture, so a host can set up the high part of the next address while the current cycle is still running. If the strobe ends before the data has arrived, the pending lookup is dropped, the bus stays released, and a sticky error flag is raised.

Top module: `rom_responder`

## Requirements
- R1: While reset is held and on the first cycle after it, `data_oe`, `data_out`, `marker` and `late_err` are all 0. Reset also loads the upper-address field from `hi_cfg`.
- R2: The strobe passes through a two-flop synchronizer unless SYNC_BYPASS is set. With the default, a fall of `rd_n` is captured on the third rising clock edge after it. Holding `rd_n` low gives exactly one capture: `marker` does not change again until `rd_n` has risen and fallen once more.
- R3: The lookup address is {upper field, `addr_lo[7:1]`, 0}, and the word index is {upper field, `addr_lo[7:1]`}. `addr_lo[0]` has no effect on the returned word, and every queued request has bit 0 cleared.
- R4: At each capture the upper field is reloaded from `hi_cfg`. The read being captured uses the value loaded at the previous capture, or at reset.
- R5: The word stored at index n is 0xC000 OR ((((n*37) mod 65536) XOR 0x0B5A) AND 0x3FFF).
- R6: On the capture edge `data_oe` becomes 1 while `data_out` stays 0. `data_out` takes the looked-up word on rising edge 5+LAT after the fall of `rd_n` (edge 9 with the default LAT of 4), and not before.
- R7: Once data is driven, the third rising edge after `rd_n` rises clears `data_oe` and returns `data_out` to 0. The edge before it still shows the bus enabled.
- R8: `marker` toggles on the capture edge and on the edge after `data_out` is loaded, and at no other time.
- R9: If `rd_n` rises before the word is driven, the third edge after the rise clears `data_oe`. `data_out` stays 0, `marker` does not make its second toggle, and `late_err` goes to 1 and stays 1 until reset.
- R10: The request and response FIFOs never see a push when full or a pop when empty. A word dropped by R9 never appears later: the next read returns its own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Active-low read strobe from the bus |
| addr_lo | input | LO_W (8) | Low address lines sampled at capture |
| hi_cfg | input | ADDR_W-LO_W (2) | Upper-address value loaded at reset and at each capture |
| data_out | output | 16 | Data bus value, 0 when not driving |
| data_oe | output | 1 | Data bus output enable |
| marker | output | 1 | Latency marker, toggles at capture and after drive |
| late_err | output | 1 | Sticky flag: strobe ended before the data arrived |

## Verification
Every result is due a fixed number of clock edges after the strobe change that caused it. Capture, the output enable and the first marker toggle come on edge 3 after `rd_n` falls. The word comes on edge 5+LAT, and the second marker toggle on edge 6+LAT. The release comes on edge 3 after `rd_n` rises, and so does the abort of a late cycle. The bench drives inputs on the falling clock edge and counts falling edges from that stimulus, so each sample is taken half a cycle after the rising edge it checks. It also samples one edge early, to confirm that the output has not changed before its due edge.

// File: rtl/rom_resp_pkg.sv
package rom_resp_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DRIVE
  } bus_state_t;

  // Content rule for the emulated memory: 0xC000 | ((n*37 ^ 0x0B5A) & 0x3FFF)
  function automatic logic [DATA_W-1:0] rom_word(input int unsigned idx);
    logic [DATA_W-1:0] mix;
    mix = 16'(idx * 37) ^ 16'h0B5A;
    return 16'hC000 | (mix & 16'h3FFF);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter bit BYPASS = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic level,
  output logic fall
);

  logic prev_q;

  generate
    if (BYPASS) begin : g_bypass
      assign level = strobe_n;
    end else begin : g_sync
      logic s1_q, s2_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1_q <= 1'b1;
          s2_q <= 1'b1;
        end else begin
          s1_q <= strobe_n;
          s2_q <= s1_q;
        end
      end
      assign level = s2_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= level;
  end

  assign fall = prev_q & ~level;

endmodule

// File: rtl/small_fifo.sv
module small_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULL_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  slot_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = slot_q[rp_q];

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst || flush)
    push |-> !full);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst || flush)
    pop |-> !empty);

endmodule

// File: rtl/lookup_stage.sv
module lookup_stage
  import rom_resp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LAT    = 4,
  parameter int FIFO_D = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_push,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  input  logic              resp_pop
);

  localparam int IDX_W = ADDR_W - 1;
  localparam int WORDS = 1 << IDX_W;

  logic              take;
  logic [ADDR_W-1:0] req_dout;
  logic              req_empty, req_full, rsp_empty, rsp_full;
  logic [DATA_W-1:0] rd_q, out_data;
  logic [LAT-1:0]    v_q;

  assign take = !req_empty && !rsp_full;

  small_fifo #(.W(ADDR_W), .DEPTH(FIFO_D)) u_req (
    .clk(clk), .rst(rst), .flush(flush),
    .push(req_push), .din(req_addr),
    .pop(take), .dout(req_dout),
    .empty(req_empty), .full(req_full)
  );

  // Memory array, synchronous read so that a block RAM can be inferred
  logic [DATA_W-1:0] rom_q [WORDS];
  initial begin
    for (int i = 0; i < WORDS; i++) rom_q[i] = rom_word(i);
  end

  always_ff @(posedge clk) begin
    rd_q <= rom_q[req_dout[ADDR_W-1:1]];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      v_q <= '0;
    end else begin
      v_q[0] <= take;
      for (int i = 1; i < LAT; i++) v_q[i] <= v_q[i-1];
    end
  end

  generate
    if (LAT > 1) begin : g_delay
      logic [DATA_W-1:0] dly_q [LAT-1];
      always_ff @(posedge clk) begin
        dly_q[0] <= rd_q;
        for (int i = 1; i < LAT - 1; i++) dly_q[i] <= dly_q[i-1];
      end
      assign out_data = dly_q[LAT-2];
    end else begin : g_direct
      assign out_data = rd_q;
    end
  endgenerate

  small_fifo #(.W(DATA_W), .DEPTH(FIFO_D)) u_rsp (
    .clk(clk), .rst(rst), .flush(flush),
    .push(v_q[LAT-1] & ~flush), .din(out_data),
    .pop(resp_pop), .dout(resp_data),
    .empty(rsp_empty), .full(rsp_full)
  );

  assign resp_valid = !rsp_empty;

  // R3
  req_align_chk: assert property (@(posedge clk) disable iff (rst)
    req_push |-> (req_addr[0] == 1'b0));
  // R3
  fetch_align_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> (req_dout[0] == 1'b0));
  // R10
  req_room_chk: assert property (@(posedge clk) disable iff (rst)
    req_push |-> !req_full);

endmodule

// File: rtl/bus_fsm.sv
module bus_fsm
  import rom_resp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LO_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_level,
  input  logic                   rd_fall,
  input  logic [LO_W-1:0]        addr_lo,
  input  logic [ADDR_W-LO_W-1:0] hi_cfg,
  output logic                   req_push,
  output logic [ADDR_W-1:0]      req_addr,
  input  logic                   resp_valid,
  input  logic [DATA_W-1:0]      resp_data,
  output logic                   resp_pop,
  output logic                   abort,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_oe,
  output logic                   marker,
  output logic                   late_err
);

  localparam int HI_W = ADDR_W - LO_W;
  localparam logic [LO_W-1:0] LO_ALIGN = {{(LO_W-1){1'b1}}, 1'b0};

  bus_state_t        st_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] data_q;
  logic              oe_q, marker_q, late_q, mark_pend_q;
  logic              capture, got;

  assign capture  = (st_q == ST_IDLE) && rd_fall;
  assign abort    = (st_q == ST_WAIT) && rd_level;
  assign got      = (st_q == ST_WAIT) && !rd_level && resp_valid;
  assign req_push = capture;
  assign req_addr = {hi_q, addr_lo & LO_ALIGN};
  assign resp_pop = got;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      hi_q        <= hi_cfg;
      data_q      <= '0;
      oe_q        <= 1'b0;
      marker_q    <= 1'b0;
      late_q      <= 1'b0;
      mark_pend_q <= 1'b0;
    end else begin
      mark_pend_q <= 1'b0;
      if (mark_pend_q) marker_q <= ~marker_q;
      case (st_q)
        ST_IDLE: if (capture) begin
          st_q     <= ST_WAIT;
          oe_q     <= 1'b1;
          marker_q <= ~marker_q;
          hi_q     <= hi_cfg;
        end
        ST_WAIT: if (abort) begin
          st_q   <= ST_IDLE;
          oe_q   <= 1'b0;
          late_q <= 1'b1;
        end else if (got) begin
          st_q        <= ST_DRIVE;
          data_q      <= resp_data;
          mark_pend_q <= 1'b1;
        end
        ST_DRIVE: if (rd_level) begin
          st_q   <= ST_IDLE;
          oe_q   <= 1'b0;
          data_q <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign data_out = data_q;
  assign data_oe  = oe_q;
  assign marker   = marker_q;
  assign late_err = late_q;

  // R7
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DRIVE && rd_level) |=> (!oe_q && data_q == '0));
  // R9
  late_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    late_q |=> late_q);
  // R9
  abort_off_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!oe_q && data_q == '0 && late_q));
  // R8
  marker_when_chk: assert property (@(posedge clk) disable iff (rst)
    (marker_q != $past(marker_q)) |-> ($past(capture) || $past(mark_pend_q)));
  // R6
  drive_word_chk: assert property (@(posedge clk) disable iff (rst)
    got |=> (oe_q && data_q == $past(resp_data)));

endmodule

// File: rtl/rom_responder.sv
module rom_responder
  import rom_resp_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int LO_W        = 8,
  parameter int LAT         = 4,
  parameter int FIFO_D      = 2,
  parameter bit SYNC_BYPASS = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_n,
  input  logic [LO_W-1:0]        addr_lo,
  input  logic [ADDR_W-LO_W-1:0] hi_cfg,
  output logic [DATA_W-1:0]      data_out,
  output logic                   data_oe,
  output logic                   marker,
  output logic                   late_err
);

  logic              rd_level, rd_fall;
  logic              req_push, resp_valid, resp_pop, abort;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] resp_data;

  strobe_sync #(.BYPASS(SYNC_BYPASS)) u_sync (
    .clk(clk), .rst(rst), .strobe_n(rd_n),
    .level(rd_level), .fall(rd_fall)
  );

  bus_fsm #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_fsm (
    .clk(clk), .rst(rst),
    .rd_level(rd_level), .rd_fall(rd_fall),
    .addr_lo(addr_lo), .hi_cfg(hi_cfg),
    .req_push(req_push), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_pop(resp_pop),
    .abort(abort),
    .data_out(data_out), .data_oe(data_oe),
    .marker(marker), .late_err(late_err)
  );

  lookup_stage #(.ADDR_W(ADDR_W), .LAT(LAT), .FIFO_D(FIFO_D)) u_look (
    .clk(clk), .rst(rst), .flush(abort),
    .req_push(req_push), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_pop(resp_pop)
  );

endmodule

// File: tb/rom_responder_bench.sv
`timescale 1ns/1ps
module rom_responder_bench;

  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_n = 1'b1;
  logic [7:0]  addr_lo = '0;
  logic [1:0]  hi_cfg = 2'd2;
  logic [15:0] data_out;
  logic        data_oe, marker, late_err;

  int checks = 0;
  int failures = 0;
  logic [1:0] hi_model;

  always #2.5 clk = ~clk;

  rom_responder #(.LAT(LAT)) u_rom_responder (
    .clk(clk), .rst(rst), .rd_n(rd_n), .addr_lo(addr_lo), .hi_cfg(hi_cfg),
    .data_out(data_out), .data_oe(data_oe), .marker(marker), .late_err(late_err)
  );

  // {next hi_cfg, addr_lo}
  localparam logic [9:0] VEC [8] = '{
    {2'd0, 8'h00}, {2'd0, 8'h01}, {2'd1, 8'h7E}, {2'd2, 8'hFF},
    {2'd3, 8'h80}, {2'd3, 8'h81}, {2'd1, 8'h02}, {2'd0, 8'hFE}
  };

  function automatic logic [15:0] exp_word(input logic [8:0] n);
    logic [15:0] m;
    m = ({7'd0, n} * 16'd37) ^ 16'h0B5A;
    return 16'hC000 | (m & 16'h3FFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] lo, input logic [1:0] nxt_hi, input int hold);
    logic [15:0] exp;
    logic m0;
    exp = exp_word({hi_model, lo[7:1]});
    @(negedge clk);
    addr_lo = lo; hi_cfg = nxt_hi; m0 = marker; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(data_oe == 1'b0, "R2 no capture before edge 3", data_oe, 0);
    @(negedge clk);
    chk(data_oe == 1'b1, "R6 enable at capture", data_oe, 1);
    chk(marker == ~m0, "R8 toggle at capture", marker, ~m0);
    chk(data_out == 16'h0, "R6 bus idle before data", data_out, 0);
    repeat (LAT + 1) @(negedge clk);
    chk(data_out == 16'h0, "R6 no data one edge early", data_out, 0);
    @(negedge clk);
    chk(data_out == exp, "R5 R3 R4 word driven", data_out, exp);
    chk(marker == ~m0, "R8 no second toggle yet", marker, ~m0);
    @(negedge clk);
    chk(marker == m0, "R8 toggle after drive", marker, m0);
    repeat (hold) @(negedge clk);
    if (hold > 0) chk(marker == m0 && data_out == exp, "R2 held strobe gives one capture",
                      marker, m0);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(data_oe == 1'b1, "R7 still driving edge 2", data_oe, 1);
    @(negedge clk);
    chk(data_oe == 1'b0 && data_out == 16'h0, "R7 release", {data_oe, data_out}, 0);
    hi_model = nxt_hi;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic m0;
    repeat (3) @(negedge clk);
    chk(data_oe == 0 && data_out == 0 && marker == 0 && late_err == 0,
        "R1 state in reset", {data_oe, marker, late_err, data_out}, 0);
    rst = 1'b0;
    hi_model = 2'd2;
    @(negedge clk);
    chk(data_oe == 0 && data_out == 0 && marker == 0 && late_err == 0,
        "R1 state after reset", {data_oe, marker, late_err, data_out}, 0);

    for (int n = 0; n < 8; n++) do_read(VEC[n][7:0], VEC[n][9:8], 0);

    // R2 strobe held long after data
    do_read(8'h44, 2'd3, 12);

    // R9 strobe ends before data arrives
    @(negedge clk);
    addr_lo = 8'h20; hi_cfg = 2'd1; m0 = marker; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(data_oe == 1'b1, "R9 captured", data_oe, 1);
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(data_oe == 1'b1 && late_err == 1'b0, "R9 not yet aborted",
        {data_oe, late_err}, 2'b10);
    @(negedge clk);
    chk(data_oe == 1'b0 && late_err == 1'b1, "R9 abort", {data_oe, late_err}, 2'b01);
    begin
      bit quiet = 1'b1;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (data_oe || data_out != 0 || marker != ~m0) quiet = 1'b0;
      end
      chk(quiet, "R9 dropped word stays off bus", {data_oe, data_out}, 0);
    end
    hi_model = 2'd1;

    // R10 next read gets its own word after the flush
    do_read(8'h13, 2'd0, 0);
    chk(late_err == 1'b1, "R9 late flag sticky", late_err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule